// File: doc/BRIEF.md
# Check-Field Infrared Pulse Encoder

This block turns a 31-bit scancode into an infrared transmit envelope. The envelope is a series of fixed-length time units, and each unit is either a pulse (envelope 1) or a space (envelope 0). A frame begins with one pulse unit as a header. Bit positions are then sent from 30 down to 0. Each position takes two units: first a check unit, then a data unit.

The data unit is a space when the bit is one and a pulse when the bit is zero. At a fixed set of positions, the check unit is a pulse only when the current bit and the bit above it are both zero. At every other position the check unit is a space. Adjacent units of equal level form one longer run on the wire without extra logic.

After the last data unit the encoder holds a trailing space for sixty units, so a frame never ends on a pulse. It then becomes ready for the next scancode. A second output gates the envelope with a free-running square-wave carrier, ready to drive an emitter directly.

Top module: `ir_chk_encoder`

## Requirements
- R1: After synchronous reset, `in_ready` is 1 and both `tx_env` and `tx_mod` are 0.
- R2: A scancode is taken on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the next cycle until the trailing space ends. `in_valid` and `in_code` have no effect on the outputs while `in_ready` is 0.
- R3: In the cycle after acceptance, `tx_env` rises and stays at 1 for exactly one unit (the header).
- R4: For each position p from 30 down to 0, a check unit is sent and then a data unit. The data unit is 0 when code bit p is 1 and 1 when code bit p is 0.
- R5: At positions 9–14, 16–22, 24, 25 and 30 (mask 0x437F7E00), the check unit is 1 exactly when code bits p and p+1 are both 0. Bit 31 is taken as 0.
- R6: At every position outside that mask, the check unit is 0 whatever the code.
- R7: After data unit 0, `tx_env` stays 0 for 60 units. `in_ready` returns to 1 in the cycle after the last of those units.
- R8: One unit lasts floor(floor(CLK_HZ/1000)·416/1000) clock cycles, which at the default 50 MHz clock is 20800 cycles (416 µs).
- R9: The carrier starts low after reset, runs freely and toggles every floor(CLK_HZ/(2·38000)) cycles. `tx_mod` is `tx_env` AND the carrier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Scancode offered |
| in_code | input | 31 | Scancode to transmit |
| in_ready | output | 1 | Encoder idle, will take a scancode |
| tx_env | output | 1 | Transmit envelope, 1 = pulse |
| tx_mod | output | 1 | Envelope gated with the carrier |

## Verification
Two events can fall in the same cycle: the end of the trailing space and the acceptance of the next scancode. The bench provokes this by holding `in_valid` high through the whole gap, so the new frame is taken in the first cycle that `in_ready` is 1. The behavioural model expects that frame's header one cycle later, with no idle cycle in between, and compares it on every clock. The model also drives `in_valid` high with a different scancode while a frame is in progress. It expects the envelope to stay unchanged, which checks that input is ignored while busy.

// File: rtl/ir_enc_pkg.sv
package ir_enc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR,
        ST_CHK,
        ST_DAT,
        ST_GAP
    } phase_e;

    // Cycles per signalling unit from clock frequency and unit length in us
    function automatic int unsigned unit_cycles(longint unsigned clk_hz,
                                                int unsigned unit_us);
        longint unsigned khz;
        khz = clk_hz / 64'd1000;
        return int'((khz * longint'(unit_us)) / 64'd1000);
    endfunction

    // Cycles per carrier half period
    function automatic int unsigned half_cycles(longint unsigned clk_hz,
                                                int unsigned car_hz);
        return int'(clk_hz / (64'd2 * longint'(car_hz)));
    endfunction

    // Width of a counter that reaches n-1 (at least 1)
    function automatic int unsigned cnt_width(int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ir_unit_timer.sv
module ir_unit_timer
    import ir_enc_pkg::*;
#(
    parameter int unsigned UNIT_CYC = 20800
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = cnt_width(UNIT_CYC);
    localparam logic [CW-1:0] LAST = CW'(UNIT_CYC - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen
    import ir_enc_pkg::*;
#(
    parameter int unsigned HALF_CYC = 657
) (
    input  logic clk,
    input  logic rst,
    output logic carrier
);
    localparam int unsigned CW = cnt_width(HALF_CYC);
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            carrier <= 1'b0;
        end else if (cnt == LAST) begin
            cnt     <= '0;
            carrier <= ~carrier;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ir_frame_seq.sv
module ir_frame_seq
    import ir_enc_pkg::*;
#(
    parameter int unsigned     NBITS     = 31,
    parameter int unsigned     GAP_UNITS = 60,
    parameter logic [NBITS-1:0] CHK_MASK = 31'h437F7E00
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [NBITS-1:0] in_code,
    input  logic             unit_tick,
    output logic             in_ready,
    output logic             busy,
    output logic             env
);
    localparam int unsigned PW = cnt_width(NBITS);
    localparam int unsigned GW = cnt_width(GAP_UNITS);
    localparam logic [PW-1:0] TOP_POS  = PW'(NBITS - 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(GAP_UNITS - 1);

    phase_e         phase;
    logic [PW-1:0]  pos;
    logic [GW-1:0]  gcnt;
    logic [NBITS:0] code_ext;   // one extra zero bit above the top position

    logic cur_bit, upper_bit, chk_lvl;

    assign cur_bit   = code_ext[pos];
    assign upper_bit = code_ext[pos + 1'b1];
    assign chk_lvl   = CHK_MASK[pos] & ~cur_bit & ~upper_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= ST_IDLE;
            pos      <= '0;
            gcnt     <= '0;
            code_ext <= '0;
        end else begin
            case (phase)
                ST_IDLE: begin
                    if (in_valid) begin
                        code_ext <= {1'b0, in_code};
                        phase    <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (unit_tick) begin
                        phase <= ST_CHK;
                        pos   <= TOP_POS;
                    end
                end
                ST_CHK: begin
                    if (unit_tick) phase <= ST_DAT;
                end
                ST_DAT: begin
                    if (unit_tick) begin
                        if (pos == '0) begin
                            phase <= ST_GAP;
                            gcnt  <= '0;
                        end else begin
                            pos   <= pos - 1'b1;
                            phase <= ST_CHK;
                        end
                    end
                end
                ST_GAP: begin
                    if (unit_tick) begin
                        if (gcnt == GAP_LAST) phase <= ST_IDLE;
                        else                  gcnt  <= gcnt + 1'b1;
                    end
                end
                default: phase <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        unique case (phase)
            ST_HDR:  env = 1'b1;
            ST_CHK:  env = chk_lvl;
            ST_DAT:  env = ~cur_bit;
            default: env = 1'b0;
        endcase
    end

    assign in_ready = (phase == ST_IDLE);
    assign busy     = ~in_ready;
endmodule

// File: rtl/ir_chk_encoder.sv
module ir_chk_encoder
    import ir_enc_pkg::*;
#(
    parameter longint unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned     UNIT_US    = 416,
    parameter int unsigned     CARRIER_HZ = 38_000,
    parameter int unsigned     NBITS      = 31,
    parameter logic [NBITS-1:0] CHK_MASK  = 31'h437F7E00
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [NBITS-1:0] in_code,
    output logic             in_ready,
    output logic             tx_env,
    output logic             tx_mod
);
    localparam int unsigned UNIT_CYC  = unit_cycles(CLK_HZ, UNIT_US);
    localparam int unsigned HALF_CYC  = half_cycles(CLK_HZ, CARRIER_HZ);
    localparam int unsigned GAP_UNITS = 2 * (NBITS - 1);

    logic busy, unit_tick, carrier;

    ir_unit_timer #(.UNIT_CYC(UNIT_CYC)) u_tmr (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (unit_tick)
    );

    ir_frame_seq #(
        .NBITS     (NBITS),
        .GAP_UNITS (GAP_UNITS),
        .CHK_MASK  (CHK_MASK)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_code   (in_code),
        .unit_tick (unit_tick),
        .in_ready  (in_ready),
        .busy      (busy),
        .env       (tx_env)
    );

    ir_carrier_gen #(.HALF_CYC(HALF_CYC)) u_car (
        .clk     (clk),
        .rst     (rst),
        .carrier (carrier)
    );

    assign tx_mod = tx_env & carrier;
endmodule

// File: rtl/ir_chk_encoder_chk.sv
module ir_chk_encoder_chk #(
    parameter longint unsigned CLK_HZ   = 50_000_000,
    parameter int unsigned     UNIT_US  = 416,
    parameter int unsigned     UNIT_CYC = 20800
) (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_ready,
    input logic tx_env,
    input logic tx_mod,
    input logic unit_tick
);
    int unsigned span;

    always_ff @(posedge clk) begin
        if (rst || in_ready || unit_tick) span <= 0;
        else                              span <= span + 1;
    end

    // R8
    initial begin
        unit_len_static_chk: assert (
            (longint'(UNIT_CYC) * 64'd1000000 <= longint'(UNIT_US) * CLK_HZ) &&
            ((longint'(UNIT_CYC) + 64'd1) * 64'd1000000 > longint'(UNIT_US) * CLK_HZ));
    end

    // R8
    unit_len_chk: assert property (@(posedge clk) disable iff (rst)
        unit_tick |-> (span == UNIT_CYC - 1));

    // R2
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> !in_ready);

    // R3
    header_start_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> tx_env);

    // R9
    mod_gate_chk: assert property (@(posedge clk) disable iff (rst)
        tx_mod |-> tx_env);

    // R7
    idle_space_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !tx_env);
endmodule

bind ir_chk_encoder ir_chk_encoder_chk #(
    .CLK_HZ   (CLK_HZ),
    .UNIT_US  (UNIT_US),
    .UNIT_CYC (UNIT_CYC)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .tx_env    (tx_env),
    .tx_mod    (tx_mod),
    .unit_tick (unit_tick)
);

// File: tb/sim_ir_chk_encoder.sv
module sim_ir_chk_encoder;
    localparam longint unsigned CLK_HZ = 250_000;   // scaled timing for a short run
    localparam int UNIT  = int'((CLK_HZ / 1000) * 416 / 1000);
    localparam int HALF  = int'(CLK_HZ / (2 * 38000));
    localparam int TOTAL = 1 + 62 + 60;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [30:0] in_code = '0;
    logic        in_ready, tx_env, tx_mod;

    always #10 clk = ~clk;   // 50 MHz

    ir_chk_encoder #(.CLK_HZ(CLK_HZ)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
        .in_ready(in_ready), .tx_env(tx_env), .tx_mod(tx_mod)
    );

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    bit done    = 0;

    // ---------------- behavioural reference model ----------------
    bit m_busy, m_car;
    int m_idx, m_cyc, m_ccnt;
    bit lv[TOTAL];

    function automatic bit is_chk_pos(int p);
        case (p)
            30, 25, 24, 22, 21, 20, 19, 18, 17, 16,
            14, 13, 12, 11, 10, 9: return 1'b1;
            default:               return 1'b0;
        endcase
    endfunction

    function automatic bit cbit(logic [30:0] c, int p);
        return (p > 30) ? 1'b0 : c[p];
    endfunction

    task automatic build(logic [30:0] c);
        int k = 0;
        lv[k++] = 1'b1;
        for (int p = 30; p >= 0; p--) begin
            lv[k++] = is_chk_pos(p) && !cbit(c, p) && !cbit(c, p + 1);
            lv[k++] = !c[p];
        end
        while (k < TOTAL) lv[k++] = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_busy = 0; m_idx = 0; m_cyc = 0; m_ccnt = 0; m_car = 0;
        end else begin
            m_ccnt++;
            if (m_ccnt == HALF) begin m_ccnt = 0; m_car = !m_car; end
            if (m_busy) begin
                m_cyc++;
                if (m_cyc == UNIT) begin
                    m_cyc = 0;
                    m_idx++;
                    if (m_idx == TOTAL) m_busy = 0;
                end
            end else if (in_valid) begin
                build(in_code);
                m_busy = 1; m_idx = 0; m_cyc = 0;
            end
        end
    end

    function automatic string tag_of();
        if (!m_busy)        return "R2";
        if (m_idx == 0)     return "R3";
        if (m_idx >= 63)    return "R7";
        if (m_idx % 2 == 1) return is_chk_pos(30 - (m_idx - 1) / 2) ? "R5" : "R6";
        return "R4";
    endfunction

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit e_env, e_rdy, e_mod;
            e_env = m_busy ? lv[m_idx] : 1'b0;
            e_rdy = !m_busy;
            e_mod = e_env & m_car;
            vectors++;
            if (tx_env !== e_env) begin
                errors++;
                $display("FAIL %s tx_env unit %0d: got %b expected %b", tag_of(), m_idx, tx_env, e_env);
            end
            if (in_ready !== e_rdy) begin
                errors++;
                $display("FAIL R2 in_ready: got %b expected %b", in_ready, e_rdy);
            end
            if (tx_mod !== e_mod) begin
                errors++;
                $display("FAIL R9 tx_mod: got %b expected %b", tx_mod, e_mod);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic report();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    task automatic wait_ready();
        while (!in_ready) @(negedge clk);
    endtask

    // offer a code, then toggle junk on the inputs while busy (R2)
    task automatic send(logic [30:0] c);
        wait_ready();
        in_valid = 1'b1; in_code = c;
        @(negedge clk);
        in_code = ~c;
        repeat (400) @(negedge clk);
        in_valid = 1'b0;
        wait_ready();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        vectors++;
        if (in_ready !== 1'b1 || tx_env !== 1'b0 || tx_mod !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset outputs: got %b%b%b expected 100", in_ready, tx_env, tx_mod);
        end

        // R8: header of an all-ones code is an isolated pulse one unit long
        wait_ready();
        in_valid = 1'b1; in_code = 31'h7FFFFFFF;
        @(negedge clk);
        in_valid = 1'b0;
        begin
            int len = 0;
            while (tx_env) begin len++; @(negedge clk); end
            vectors++;
            if (len != UNIT) begin
                errors++;
                $display("FAIL R8 header length: got %0d expected %0d", len, UNIT);
            end
        end
        wait_ready();
        @(negedge clk);

        send(31'h00000000);   // R5: every masked check unit pulses
        send(31'h2AAAAAAA);   // R4/R6: alternating bits
        send(31'h15555555);
        send(31'h3C5A9E01);

        // back-to-back: valid held through the gap end
        in_valid = 1'b1; in_code = 31'h00FF00F0;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_code = 31'h4000_0001;   // taken in the first ready cycle
        @(negedge clk);
        in_valid = 1'b0;
        wait_ready();
        repeat (5) @(negedge clk);
        report();
    end

    initial begin
        wait (cycles >= 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got %0d cycles expected completion", cycles);
            report();
        end
    end
endmodule